// File: doc/BRIEF.md
# Single-Wire Peripheral Bus Codec

This block is the host end of a slow, open-drain, single-wire bus shared by several peripherals. Every bit takes a fixed 100 us cell: the driver pulls the line low at the start of the cell and releases it later. A short low pulse means one and a long one means zero. The block sends command bytes on the wire, times the low pulses that a peripheral drives back, and rebuilds the reply byte for the host. All timing comes from a microsecond tick that is divided down from the system clock.

Once some peripheral has returned data, that peripheral is the active one. Whenever the block is idle and the host has no command waiting, it polls the active peripheral again. A reply raises a one-cycle data strobe along with the byte and the address that was polled. Any peripheral can flag that it has data by holding the line low late in the stop cell of a command. The block reports this to the host on an active-low service-request status line. The host then issues its own commands to find out which peripheral asked.

Top module: `swb_codec`

## Requirements
- R1: After reset the line is released, `srq_no_o` is high, `cmd_ready_o` is high, and `rx_valid_o` is low. No poll is sent until some peripheral has replied.
- R2: Each transmitted cell is exactly 100 us long. A one holds the line low for the first 35 us of the cell and a zero holds it low for the first 65 us. The line is released for the rest of the cell.
- R3: A command is the 8 bits of the byte, most significant bit first, then one stop cell that carries a zero.
- R4: A reply is one start cell, then 8 data cells MSB first, then a stop cell. A low pulse shorter than 50 us decodes as one and any longer pulse decodes as zero. After the eighth data bit, `rx_valid_o` pulses for one cycle with the byte and the address of the polled peripheral.
- R5: The command byte carries the peripheral address in bits [7:4]. When idle with no host command, the block sends the poll byte {active address, POLL_CODE}, where POLL_CODE defaults to 4'hC.
- R6: If no start pulse arrives within 260 us after the stop cell, the exchange ends with no data and the active address stays as it was.
- R7: A low pulse longer than 300 us during a reply abandons the byte with no `rx_valid_o` and leaves the active address unchanged. The next reply is received normally.
- R8: The block samples the line 90 us into every stop cell it sends. If the line is low there, `srq_no_o` goes low; if it is high, `srq_no_o` goes high. The output changes at no other time.
- R9: `cmd_ready_o` is high only when idle. A host command that is valid when idle is accepted ahead of a pending auto-poll and is transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Sensed level of the shared line |
| bus_pull_o | output | 1 | 1 pulls the line low, 0 releases it |
| cmd_valid_i | input | 1 | Host command byte present |
| cmd_byte_i | input | 8 | Host command byte, address in [7:4] |
| cmd_ready_o | output | 1 | Command accepted on this cycle if valid |
| rx_valid_o | output | 1 | One-cycle strobe for a received reply |
| rx_data_o | output | 8 | Received reply byte |
| rx_addr_o | output | ADDR_W | Address of the peripheral that replied |
| srq_no_o | output | 1 | Service request seen, active low |

## Verification
Most internal faults in this block show up at the ports within one bit cell. A wrong cell counter or bit index changes a pulse width or the number of cells in the next command. A wrong pulse-counter state in the receiver moves every following bit one place, so the reply byte or its strobe is wrong as soon as that reply ends. A corrupted active address or timeout counter shows up on the next auto-poll, which either names the wrong peripheral or starts too early or too late. A late or misplaced line sample shows up on `srq_no_o` when the stop cell that carries the request ends.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int BYTE_W      = 8;
  localparam int CELL_US     = 100;
  localparam int ONE_LOW_US  = 35;
  localparam int ZERO_LOW_US = 65;
  localparam int SPLIT_US    = 50;
  localparam int ATTN_US     = 300;
  localparam int RESP_TMO_US = 260;
  localparam int SRQ_SMP_US  = 90;
  localparam int GAP_US      = 200;
  localparam int CELL_W      = $clog2(CELL_US);
  localparam int TMR_W       = $clog2(ATTN_US + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_GAP
  } ctl_state_e;
endpackage

// File: rtl/swb_tick.sv
module swb_tick #(
  parameter int CLKS_PER_US = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLKS_PER_US <= 1) begin : g_direct
      logic tick_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) tick_q <= 1'b0;
        else         tick_q <= 1'b1;
      assign tick_o = tick_q;
    end else begin : g_div
      localparam int DW = $clog2(CLKS_PER_US);
      localparam logic [DW-1:0] LAST = DW'(CLKS_PER_US - 1);
      logic [DW-1:0] cnt;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) cnt <= '0;
        else         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      assign tick_o = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/swb_tx.sv
module swb_tx import swb_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic              pull_o,
  output logic              done_o,
  output logic              smp_o
);
  localparam int IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0]  STOP_IDX  = IDX_W'(BYTE_W);
  localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(CELL_US - 1);
  localparam logic [CELL_W-1:0] ONE_LEN   = CELL_W'(ONE_LOW_US);
  localparam logic [CELL_W-1:0] ZERO_LEN  = CELL_W'(ZERO_LOW_US);
  localparam logic [CELL_W-1:0] SMP_AT    = CELL_W'(SRQ_SMP_US);

  logic [IDX_W-1:0]  idx;
  logic [CELL_W-1:0] us;
  logic [BYTE_W-1:0] sh;
  logic in_stop, cell_end;

  assign in_stop  = (idx == STOP_IDX);
  assign cell_end = busy_o && tick_i && (us == CELL_LAST);
  // stop cell always carries a zero
  assign pull_o   = busy_o && (us < ((!in_stop && sh[BYTE_W-1]) ? ONE_LEN : ZERO_LEN));
  assign done_o   = cell_end && in_stop;
  assign smp_o    = busy_o && tick_i && in_stop && (us == SMP_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx    <= '0;
      us     <= '0;
      sh     <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      idx    <= '0;
      us     <= '0;
      sh     <= byte_i;
    end else if (cell_end) begin
      us <= '0;
      if (in_stop) busy_o <= 1'b0;
      else begin
        idx <= idx + 1'b1;
        sh  <= {sh[BYTE_W-2:0], 1'b0};
      end
    end else if (busy_o && tick_i) begin
      us <= us + 1'b1;
    end
  end

  assert_no_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  assert_stop_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(in_stop));
endmodule

// File: rtl/swb_rx.sv
module swb_rx import swb_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              en_i,
  output logic              line_s_o,
  output logic              fall_o,
  output logic              attn_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int NW = $clog2(BYTE_W + 1);
  localparam logic [NW-1:0]    LAST_BIT = NW'(BYTE_W);
  localparam logic [TMR_W-1:0] SPLIT    = TMR_W'(SPLIT_US);
  localparam logic [TMR_W-1:0] ATTN_LIM = TMR_W'(ATTN_US);

  logic s1, s2, prev;
  logic [TMR_W-1:0] low_cnt;
  logic own, dead;
  logic [NW-1:0] npulse;
  logic [BYTE_W-1:0] sh;
  logic rise, bit_evt, bit_val;

  assign line_s_o = s2;
  assign fall_o   = prev && !s2;
  assign rise     = !prev && s2;
  assign attn_o   = !s2 && !fall_o && tick_i && !dead && (low_cnt == ATTN_LIM);
  assign bit_evt  = rise && own && !dead;
  assign bit_val  = (low_cnt < SPLIT);
  assign byte_o   = sh;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) {s1, s2, prev} <= 3'b111;
    else         {s1, s2, prev} <= {line_i, s1, s2};

  // low-pulse width in us; pulses that began while disabled are not counted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      own     <= 1'b0;
      dead    <= 1'b0;
    end else if (fall_o) begin
      low_cnt <= TMR_W'(1);
      own     <= en_i;
      dead    <= 1'b0;
    end else if (attn_o) begin
      dead <= 1'b1;
    end else if (!s2 && tick_i && !dead) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npulse     <= '0;
      sh         <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= en_i && bit_evt && (npulse == LAST_BIT);
      if (!en_i || attn_o) npulse <= '0;
      else if (bit_evt) begin
        if (npulse != '0) sh <= {sh[BYTE_W-2:0], bit_val};
        npulse <= (npulse == LAST_BIT) ? '0 : npulse + 1'b1;
      end
    end
  end

  assert_vld_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
  assert_attn_no_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_o |=> !byte_vld_o);
endmodule

// File: rtl/swb_codec.sv
module swb_codec import swb_pkg::*; #(
  parameter int CLKS_PER_US = 8,
  parameter int ADDR_W      = 4,
  parameter logic [BYTE_W-ADDR_W-1:0] POLL_CODE = 'hC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_i,
  output logic              bus_pull_o,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_byte_i,
  output logic              cmd_ready_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic [ADDR_W-1:0] rx_addr_o,
  output logic              srq_no_o
);
  localparam logic [TMR_W-1:0] TMO_LAST = TMR_W'(RESP_TMO_US - 1);
  localparam logic [TMR_W-1:0] GAP_LAST = TMR_W'(GAP_US - 1);

  ctl_state_e        state;
  logic [TMR_W-1:0]  tmr;
  logic [ADDR_W-1:0] act_addr, cur_addr;
  logic              act_vld;
  logic              tick, tx_start, tx_busy, tx_done, tx_smp;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic              rx_en, line_s, rx_fall, rx_attn, rx_vld;

  swb_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  swb_tx u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .start_i(tx_start),
    .byte_i(tx_byte), .busy_o(tx_busy), .pull_o(bus_pull_o),
    .done_o(tx_done), .smp_o(tx_smp));

  swb_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .line_i(bus_i),
    .en_i(rx_en), .line_s_o(line_s), .fall_o(rx_fall), .attn_o(rx_attn),
    .byte_vld_o(rx_vld), .byte_o(rx_byte));

  always_comb begin
    cmd_ready_o = (state == ST_IDLE);
    tx_start    = (state == ST_IDLE) && (cmd_valid_i || act_vld);
    tx_byte     = cmd_valid_i ? cmd_byte_i : {act_addr, POLL_CODE};
    rx_en       = (state == ST_WAIT) || (state == ST_RECV);
    rx_valid_o  = (state == ST_RECV) && rx_vld;
    rx_data_o   = rx_byte;
    rx_addr_o   = cur_addr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      act_addr <= '0;
      act_vld  <= 1'b0;
      cur_addr <= '0;
      srq_no_o <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (tx_start) begin
          cur_addr <= tx_byte[BYTE_W-1 -: ADDR_W];
          state    <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_smp) srq_no_o <= line_s;
          if (tx_done) begin
            tmr   <= '0;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rx_fall) begin
            tmr   <= '0;
            state <= ST_RECV;
          end else if (tick) begin
            if (tmr == TMO_LAST) begin
              tmr   <= '0;
              state <= ST_GAP;
            end else tmr <= tmr + 1'b1;
          end
        end
        ST_RECV: begin
          if (rx_vld) begin
            act_addr <= cur_addr;
            act_vld  <= 1'b1;
            tmr      <= '0;
            state    <= ST_GAP;
          end else if (rx_attn) begin
            tmr   <= '0;
            state <= ST_GAP;
          end else if (rx_fall) begin
            tmr <= '0;
          end else if (tick && line_s) begin
            // reply stalled with the line released
            if (tmr == TMO_LAST) begin
              tmr   <= '0;
              state <= ST_GAP;
            end else tmr <= tmr + 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          if (tmr == GAP_LAST) state <= ST_IDLE;
          else tmr <= tmr + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cmd_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> (state == ST_SEND) && tx_busy);
  assert_pull_in_send_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_pull_o |-> (state == ST_SEND));
  assert_rx_to_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> (state == ST_GAP));
  assert_wait_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT) |-> (tmr <= TMO_LAST));
  assert_srq_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(srq_no_o) |-> $past(state == ST_SEND));
endmodule

// File: tb/sim_swb_codec.sv
module sim_swb_codec;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] POLL = 4'hC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_pull = 1'b0;
  logic bus_line, bus_pull, cmd_valid = 1'b0, cmd_ready, rx_valid, srq_no;
  logic [7:0] cmd_byte = 8'h00, rx_data;
  logic [3:0] rx_addr;

  int total = 0, bad = 0, rx_cnt = 0, pull_cycles = 0;
  logic [7:0] rx_last = 8'h00;
  logic [3:0] rx_addr_last = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus_line = ~(bus_pull | dev_pull);

  swb_codec #(.CLKS_PER_US(1), .ADDR_W(4), .POLL_CODE(POLL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus_line), .bus_pull_o(bus_pull),
    .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte), .cmd_ready_o(cmd_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_addr_o(rx_addr),
    .srq_no_o(srq_no));

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt++;
      rx_last = rx_data;
      rx_addr_last = rx_addr;
    end
    if (bus_pull) pull_cycles++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic host_issue(input logic [7:0] b);
    int n = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    while (!cmd_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // decode one command from the block's own pull, checking cell shapes
  task automatic capture(input bit srq, output logic [7:0] got,
                         output logic stop_bit, output bit shape_ok);
    int n = 0;
    got = 8'h00; stop_bit = 1'b1; shape_ok = 1'b1;
    while (bus_pull !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) shape_ok = 1'b0;
    for (int c = 0; c < 9; c++) begin
      int w = 0;
      bit fell = 1'b0;
      logic b;
      for (int i = 0; i < 100; i++) begin
        if (i == 0 && !bus_pull) shape_ok = 1'b0;
        if (bus_pull && fell) shape_ok = 1'b0;
        if (bus_pull && !fell) w++;
        if (!bus_pull) fell = 1'b1;
        if (c == 8) dev_pull = srq && i >= 1 && i < 95;
        @(negedge clk);
      end
      dev_pull = 1'b0;
      if (w == 35) b = 1'b1;
      else if (w == 65) b = 1'b0;
      else begin
        b = 1'b1;
        shape_ok = 1'b0;
      end
      if (c < 8) got = {got[6:0], b};
      else stop_bit = b;
    end
  endtask

  // peripheral reply: start one, 8 data MSB first, stop zero
  task automatic respond(input logic [7:0] d, input int w1, input int w0,
                         input int ncells, input bit hold);
    repeat (40) @(negedge clk);
    for (int j = 0; j < ncells; j++) begin
      logic b;
      int w;
      b = (j == 0) ? 1'b1 : (j <= 8) ? d[8-j] : 1'b0;
      w = b ? w1 : w0;
      for (int i = 0; i < 100; i++) begin
        dev_pull = (i < w);
        @(negedge clk);
      end
    end
    if (hold) begin
      dev_pull = 1'b1;
      repeat (400) @(negedge clk);
    end
    dev_pull = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got, hc, dat;
    logic       stp;
    bit         ok;
    int         base, w1, w0;
    logic [3:0] addr;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_pull == 1'b0, "R1 line released", bus_pull, 0);
    chk(srq_no == 1'b1, "R1 srq idle high", srq_no, 1);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    chk(rx_valid == 1'b0, "R1 no strobe", rx_valid, 0);
    repeat (600) @(negedge clk);
    chk(pull_cycles == 0, "R1 no poll before reply", pull_cycles, 0);

    for (int k = 0; k < 16; k++) begin
      addr = 4'((k % 15) + 1);
      dat  = 8'((k * 73 + 29) & 255);
      hc   = {addr, 4'(k + 1)};
      w1   = (k == 0) ? 49 : 20 + ((k * 3) % 30);
      w0   = (k == 0) ? 50 : 50 + ((k * 7) % 40);

      host_issue(hc);
      capture(1'b0, got, stp, ok);
      chk(ok, "R2 cell widths", ok, 1);
      chk(got == hc, "R3 command bits", got, hc);
      chk(stp == 1'b0, "R3 stop zero", stp, 0);
      if (k > 0) chk(got == hc, "R9 host beats poll", got, hc);
      chk(srq_no == 1'b1, "R8 no request", srq_no, 1);

      base = rx_cnt;
      respond(dat, w1, w0, 10, 1'b0);
      chk(rx_cnt == base + 1, "R4 one strobe", rx_cnt - base, 1);
      chk(rx_last == dat, "R4 data", rx_last, dat);
      chk(rx_addr_last == addr, "R4 address", rx_addr_last, addr);

      capture(k[0], got, stp, ok);
      chk(ok && got == {addr, POLL}, "R5 auto poll", got, {addr, POLL});
      chk(srq_no == !k[0], "R8 request flag", srq_no, !k[0]);

      base = rx_cnt;
      capture(1'b0, got, stp, ok);
      chk(ok && got == {addr, POLL}, "R6 poll after timeout", got, {addr, POLL});
      chk(rx_cnt == base, "R6 no data on timeout", rx_cnt - base, 0);
      chk(srq_no == 1'b1, "R8 request cleared", srq_no, 1);
    end

    // attention pulse mid-reply
    host_issue(8'h91);
    capture(1'b0, got, stp, ok);
    chk(ok && got == 8'h91, "R3 command bits", got, 8'h91);
    base = rx_cnt;
    respond(8'hF0, 30, 70, 4, 1'b1);
    chk(rx_cnt == base, "R7 byte abandoned", rx_cnt - base, 0);
    capture(1'b0, got, stp, ok);
    chk(ok && got == {4'h1, POLL}, "R7 active kept", got, {4'h1, POLL});
    respond(8'hA5, 35, 65, 10, 1'b0);
    chk(rx_cnt == base + 1 && rx_last == 8'hA5, "R7 recovery", rx_last, 8'hA5);
    chk(rx_addr_last == 4'h1, "R7 recovery address", rx_addr_last, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule